// File: doc/BRIEF.md
# Pad Drive Compensation Code Controller

This block produces the 5-bit drive-strength compensation codes for the output pads of a parallel interface. There are two pad groups, group 0 for data pads and group 1 for strobe pads. Each group has its own control register. Each register holds a separate source-select field and a separate programmed code for the pull-up (rising-edge) driver and for the pull-down (falling-edge) driver. For each edge, the source-select field picks one of three codes:

- the latest value from the calibration circuit,
- the programmed value,
- the sum of the two, clipped at the largest code.

The block also does two housekeeping tasks for the analog calibration loop. It asks for a first calibration a fixed time after reset is released, and it asks again at a regular interval after that. It captures a calibration result only when the calibration circuit strobes a done signal. An override pin is latched when power-good rises. Its value sets the default of every source-select field, so the board can choose between automatic compensation and register-driven compensation out of reset.

Top module: `drvcomp_ctrl`

## Requirements
- R1: Source-select 2'b00 drives the captured calibrated code for that edge, one cycle after the select or the calibrated value changes.
- R2: Source-select 2'b01 drives the programmed code for that edge.
- R3: Source-select 2'b10 drives calibrated plus programmed, saturated at 5'h1F when the sum exceeds it.
- R4: Source-select 2'b11 is reserved and drives the programmed code.
- R5: A write with `wr_en` high updates only the group chosen by `wr_sel`. The write word has the rising select in bits [1:0], the falling select in [3:2], the rising programmed code in [8:4] and the falling programmed code in [13:9]. No other group's codes change.
- R6: On a rising edge of `pwr_good`, `ovr_pin` is latched. While `rst` is high or `pwr_good` is low, and on that rising edge, every select field takes its default: 2'b00 if the latched override is 0, and 2'b01 if it is 1.
- R7: The calibrated codes are captured only in a cycle with `cal_done` high. At all other times the calibration inputs have no effect on the outputs.
- R8: The first `cal_req` rises exactly FIRST_DLY cycles after the hold condition (`rst` high or `pwr_good` low) is released.
- R9: After the first request, `cal_req` repeats every CAL_PERIOD cycles, and each request is a one-cycle pulse.
- R10: After reset, the programmed codes are PROG_INIT and the calibrated codes are CAL_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good level; low holds the block in its default state |
| ovr_pin | input | 1 | Compensation override strap, latched at the rise of pwr_good |
| cal_done | input | 1 | Calibration result valid strobe |
| cal_rise | input | CODE_W | Calibrated pull-up code |
| cal_fall | input | CODE_W | Calibrated pull-down code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Target group (0 data, 1 strobe) |
| wr_data | input | 4+2*CODE_W | Register write word |
| cal_req | output | 1 | Calibration request pulse |
| rise_code | output | NGRP*CODE_W | Rising-edge codes, group g at [g*CODE_W +: CODE_W] |
| fall_code | output | NGRP*CODE_W | Falling-edge codes, group g at [g*CODE_W +: CODE_W] |

## Verification
The assertions check on every cycle that each output code follows the select field held one cycle earlier. This covers direct calibrated values, direct programmed values, a sum that never falls below either operand, and the reserved select. They also check that the captured calibration value holds steady without a done strobe, that a power-good rise loads the select defaults from the override pin, and that requests are single-cycle pulses. Some behaviour needs the bench's scenarios instead:

- the exact delay to the first request and the period after it,
- the isolation of one group from writes to the other,
- the exact clip point of the sum,
- the difference between a plain reset and a power-good cycle in how the override is applied.

// File: rtl/drvcomp_pkg.sv
package drvcomp_pkg;

  typedef enum logic [1:0] {
    SRC_CAL  = 2'b00,
    SRC_PROG = 2'b01,
    SRC_SUM  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // default source select chosen by the latched override strap
  function automatic logic [1:0] dflt_mode(input logic ovr);
    return ovr ? SRC_PROG : SRC_CAL;
  endfunction

endpackage

// File: rtl/drvcomp_sel.sv
module drvcomp_sel
  import drvcomp_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cal,
  input  logic [W-1:0] prog,
  output logic [W-1:0] code
);

  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    sum = {1'b0, cal} + {1'b0, prog};
    case (src_e'(mode))
      SRC_CAL:  nxt = cal;
      SRC_PROG: nxt = prog;
      SRC_SUM:  nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
      default:  nxt = prog;
    endcase
  end

  always_ff @(posedge clk) begin
    code <= nxt;
  end

endmodule

// File: rtl/drvcomp_regs.sv
module drvcomp_regs
  import drvcomp_pkg::*;
#(
  parameter int             NGRP      = 2,
  parameter int             W         = 5,
  parameter int             SEL_W     = 1,
  parameter logic [W-1:0]   PROG_INIT = 5'h10,
  localparam int            REG_W     = 4 + 2*W
) (
  input  logic                  clk,
  input  logic                  hold,
  input  logic                  pg_rise,
  input  logic                  ovr_pin,
  input  logic                  ovr_lat,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  output logic [NGRP-1:0][1:0]  rmode,
  output logic [NGRP-1:0][1:0]  fmode,
  output logic [NGRP-1:0][W-1:0] rprog,
  output logic [NGRP-1:0][W-1:0] fprog
);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (hold) begin
        rmode[g] <= dflt_mode(ovr_lat);
        fmode[g] <= dflt_mode(ovr_lat);
        rprog[g] <= PROG_INIT;
        fprog[g] <= PROG_INIT;
      end else if (pg_rise) begin
        rmode[g] <= dflt_mode(ovr_pin);
        fmode[g] <= dflt_mode(ovr_pin);
      end else if (wr_en && wr_sel == SEL_W'(g)) begin
        rmode[g] <= wr_data[1:0];
        fmode[g] <= wr_data[3:2];
        rprog[g] <= wr_data[4 +: W];
        fprog[g] <= wr_data[4+W +: W];
      end
    end
  end

endmodule

// File: rtl/drvcomp_sched.sv
module drvcomp_sched #(
  parameter int FIRST_DLY  = 800000,
  parameter int CAL_PERIOD = 4000000,
  localparam int MAXC      = (FIRST_DLY > CAL_PERIOD) ? FIRST_DLY : CAL_PERIOD,
  localparam int CNT_W     = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic hold,
  output logic cal_req
);

  localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(FIRST_DLY - 1);
  localparam logic [CNT_W-1:0] LIM_PER   = CNT_W'(CAL_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic             first;
  logic             hit;

  assign hit = first ? (cnt == LIM_FIRST) : (cnt == LIM_PER);

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt     <= '0;
      first   <= 1'b1;
      cal_req <= 1'b0;
    end else if (hit) begin
      cnt     <= '0;
      first   <= 1'b0;
      cal_req <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      cal_req <= 1'b0;
    end
  end

endmodule

// File: rtl/drvcomp_ctrl.sv
module drvcomp_ctrl
  import drvcomp_pkg::*;
#(
  parameter int                 CODE_W     = 5,
  parameter int                 NGRP       = 2,
  parameter int                 FIRST_DLY  = 800000,
  parameter int                 CAL_PERIOD = 4000000,
  parameter logic [CODE_W-1:0]  CAL_INIT   = 5'h10,
  parameter logic [CODE_W-1:0]  PROG_INIT  = 5'h10,
  localparam int                SEL_W      = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int                REG_W      = 4 + 2*CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_good,
  input  logic                     ovr_pin,
  input  logic                     cal_done,
  input  logic [CODE_W-1:0]        cal_rise,
  input  logic [CODE_W-1:0]        cal_fall,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [REG_W-1:0]         wr_data,
  output logic                     cal_req,
  output logic [NGRP*CODE_W-1:0]   rise_code,
  output logic [NGRP*CODE_W-1:0]   fall_code
);

  logic pg_q;
  logic pg_rise;
  logic ovr_lat;
  logic hold;

  logic [CODE_W-1:0] cal_rq;
  logic [CODE_W-1:0] cal_fq;

  logic [NGRP-1:0][1:0]        rmode;
  logic [NGRP-1:0][1:0]        fmode;
  logic [NGRP-1:0][CODE_W-1:0] rprog;
  logic [NGRP-1:0][CODE_W-1:0] fprog;

  assign hold    = rst | ~pwr_good;
  assign pg_rise = pwr_good & ~pg_q;

  // power-good edge detect and strap latch are outside the reset domain
  always_ff @(posedge clk) begin
    pg_q <= pwr_good;
    if (pg_rise) ovr_lat <= ovr_pin;
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      cal_rq <= CAL_INIT;
      cal_fq <= CAL_INIT;
    end else if (cal_done) begin
      cal_rq <= cal_rise;
      cal_fq <= cal_fall;
    end
  end

  drvcomp_regs #(
    .NGRP(NGRP), .W(CODE_W), .SEL_W(SEL_W), .PROG_INIT(PROG_INIT)
  ) u_regs (
    .clk(clk), .hold(hold), .pg_rise(pg_rise), .ovr_pin(ovr_pin),
    .ovr_lat(ovr_lat), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rmode(rmode), .fmode(fmode), .rprog(rprog), .fprog(fprog)
  );

  drvcomp_sched #(
    .FIRST_DLY(FIRST_DLY), .CAL_PERIOD(CAL_PERIOD)
  ) u_sched (
    .clk(clk), .hold(hold), .cal_req(cal_req)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_out
    drvcomp_sel #(.W(CODE_W)) u_rsel (
      .clk(clk), .mode(rmode[g]), .cal(cal_rq), .prog(rprog[g]),
      .code(rise_code[g*CODE_W +: CODE_W])
    );
    drvcomp_sel #(.W(CODE_W)) u_fsel (
      .clk(clk), .mode(fmode[g]), .cal(cal_fq), .prog(fprog[g]),
      .code(fall_code[g*CODE_W +: CODE_W])
    );
  end

endmodule

// File: rtl/drvcomp_chk.sv
module drvcomp_chk #(
  parameter int CODE_W = 5,
  parameter int NGRP   = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        pwr_good,
  input logic                        ovr_pin,
  input logic                        cal_done,
  input logic                        cal_req,
  input logic [NGRP-1:0][1:0]        rmode,
  input logic [NGRP-1:0][1:0]        fmode,
  input logic [NGRP-1:0][CODE_W-1:0] rprog,
  input logic [NGRP-1:0][CODE_W-1:0] fprog,
  input logic [CODE_W-1:0]           cal_rq,
  input logic [CODE_W-1:0]           cal_fq,
  input logic [NGRP*CODE_W-1:0]      rise_code,
  input logic [NGRP*CODE_W-1:0]      fall_code
);

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    p_cal_direct_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rmode[g]) == 2'b00) |-> (rise_code[g*CODE_W +: CODE_W] == $past(cal_rq)));

    p_cal_direct_fall_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(fmode[g]) == 2'b00) |-> (fall_code[g*CODE_W +: CODE_W] == $past(cal_fq)));

    p_prog_direct_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(rmode[g]) == 2'b01) |-> (rise_code[g*CODE_W +: CODE_W] == $past(rprog[g])));

    p_prog_direct_fall_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(fmode[g]) == 2'b01) |-> (fall_code[g*CODE_W +: CODE_W] == $past(fprog[g])));

    p_sum_floor_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(rmode[g]) == 2'b10) |->
        (rise_code[g*CODE_W +: CODE_W] >= $past(cal_rq) &&
         rise_code[g*CODE_W +: CODE_W] >= $past(rprog[g])));

    p_rsvd_prog_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(rmode[g]) == 2'b11) |-> (rise_code[g*CODE_W +: CODE_W] == $past(rprog[g])));

    p_pg_default_r6: assert property (@(posedge clk) disable iff (rst)
      (pwr_good && !$past(pwr_good)) |=>
        (rmode[g] == {1'b0, $past(ovr_pin)} && fmode[g] == {1'b0, $past(ovr_pin)}));
  end

  p_cal_hold_r7: assert property (@(posedge clk) disable iff (rst || !pwr_good)
    !cal_done |=> ($stable(cal_rq) && $stable(cal_fq)));

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst || !pwr_good)
    cal_req |=> !cal_req);

endmodule

bind drvcomp_ctrl drvcomp_chk #(.CODE_W(CODE_W), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .ovr_pin(ovr_pin),
  .cal_done(cal_done), .cal_req(cal_req),
  .rmode(rmode), .fmode(fmode), .rprog(rprog), .fprog(fprog),
  .cal_rq(cal_rq), .cal_fq(cal_fq),
  .rise_code(rise_code), .fall_code(fall_code)
);

// File: tb/sim_drvcomp_ctrl.sv
`timescale 1ns/1ps
module sim_drvcomp_ctrl;

  localparam int         W      = 5;
  localparam int         NG     = 2;
  localparam int         FD     = 40;
  localparam int         CP     = 100;
  localparam logic [4:0] CAL_I  = 5'h08;
  localparam logic [4:0] PROG_I = 5'h14;

  logic          clk = 1'b0;
  logic          rst, pwr_good, ovr_pin, cal_done, wr_en;
  logic [W-1:0]  cal_rise, cal_fall;
  logic [0:0]    wr_sel;
  logic [13:0]   wr_data;
  logic          cal_req;
  logic [NG*W-1:0] rise_code, fall_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0]   m_rmode [NG];
  logic [1:0]   m_fmode [NG];
  logic [W-1:0] m_rprog [NG];
  logic [W-1:0] m_fprog [NG];
  logic [W-1:0] m_cal_r, m_cal_f;

  always #2.5 clk = ~clk;

  drvcomp_ctrl #(
    .CODE_W(W), .NGRP(NG), .FIRST_DLY(FD), .CAL_PERIOD(CP),
    .CAL_INIT(CAL_I), .PROG_INIT(PROG_I)
  ) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .ovr_pin(ovr_pin),
    .cal_done(cal_done), .cal_rise(cal_rise), .cal_fall(cal_fall),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cal_req(cal_req), .rise_code(rise_code), .fall_code(fall_code)
  );

  function automatic logic [W-1:0] exp_code(input logic [1:0] m,
                                            input logic [W-1:0] c,
                                            input logic [W-1:0] p);
    int s;
    case (m)
      2'b00: return c;
      2'b10: begin
        s = int'(c) + int'(p);
        return (s > 31) ? 5'h1F : W'(s);
      end
      default: return p;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic model_defaults(input logic ovr);
    for (int g = 0; g < NG; g++) begin
      m_rmode[g] = ovr ? 2'b01 : 2'b00;
      m_fmode[g] = ovr ? 2'b01 : 2'b00;
      m_rprog[g] = PROG_I;
      m_fprog[g] = PROG_I;
    end
    m_cal_r = CAL_I;
    m_cal_f = CAL_I;
  endtask

  task automatic check_val(input string req, input string ctx,
                           input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, ctx, got, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int g = 0; g < NG; g++) begin
      check_val(tag(m_rmode[g]), $sformatf("%s g%0d rise", ctx, g),
                rise_code[g*W +: W], exp_code(m_rmode[g], m_cal_r, m_rprog[g]));
      check_val(tag(m_fmode[g]), $sformatf("%s g%0d fall", ctx, g),
                fall_code[g*W +: W], exp_code(m_fmode[g], m_cal_f, m_fprog[g]));
    end
  endtask

  // R5: write word {fprog[13:9], rprog[8:4], fmode[3:2], rmode[1:0]}
  task automatic do_write(input int g, input logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'(g); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_rmode[g] = d[1:0];  m_fmode[g] = d[3:2];
    m_rprog[g] = d[8:4];  m_fprog[g] = d[13:9];
    @(negedge clk);
    check_all("R5 write");
  endtask

  // R7: calibration inputs matter only with cal_done
  task automatic do_cal(input logic [W-1:0] r, input logic [W-1:0] f, input logic strobe);
    @(negedge clk);
    cal_rise = r; cal_fall = f; cal_done = strobe;
    @(negedge clk);
    cal_done = 1'b0;
    cal_rise = ~r; cal_fall = ~f;
    if (strobe) begin m_cal_r = r; m_cal_f = f; end
    @(negedge clk);
    check_all(strobe ? "R7 capture" : "R7 ignored");
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int seed;
    rst = 1'b1; pwr_good = 1'b0; ovr_pin = 1'b0; cal_done = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; cal_rise = '0; cal_fall = '0;
    seed = $urandom(32'd7);
    repeat (4) @(negedge clk);
    ovr_pin = 1'b1; pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_defaults(1'b1);

    // R10 / R6 reset state and R8 first request delay
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check_all("R10 reset state");
        checks++;
        if (cal_req !== 1'b0) begin
          errors++; $display("FAIL R8 early req got %b exp 0", cal_req);
        end
      end
      if (cal_req || n > FD + 5) break;
    end
    checks++;
    if (n != FD) begin errors++; $display("FAIL R8 first delay got %0d exp %0d", n, FD); end

    // R9 pulse width and period
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        checks++;
        if (cal_req !== 1'b0) begin
          errors++; $display("FAIL R9 pulse width got %b exp 0", cal_req);
        end
      end
      if (cal_req || n > CP + 5) break;
    end
    checks++;
    if (n != CP) begin errors++; $display("FAIL R9 period got %0d exp %0d", n, CP); end

    // R3 directed saturation corners
    do_write(0, {5'h0B, 5'h1F, 2'b10, 2'b10});
    do_cal(5'h10, 5'h15, 1'b1);
    do_cal(5'h00, 5'h14, 1'b1);
    do_write(0, {5'h10, 5'h0F, 2'b10, 2'b10});
    do_cal(5'h10, 5'h0F, 1'b1);
    // R4 reserved select, R5 isolation of group 0
    do_write(1, {5'h03, 5'h1C, 2'b11, 2'b11});
    do_cal(5'h1F, 5'h1F, 1'b0);

    // R6 power-good cycle with override low
    @(negedge clk); pwr_good = 1'b0; ovr_pin = 1'b0;
    repeat (3) @(negedge clk);
    pwr_good = 1'b1;
    model_defaults(1'b0);
    repeat (2) @(negedge clk);
    check_all("R6 pg override0");
    check_val("R6", "g0 rise default", rise_code[4:0], CAL_I);

    // R6 plain reset keeps latched override even if the pin changes
    ovr_pin = 1'b1;
    pulse_reset();
    model_defaults(1'b0);
    repeat (2) @(negedge clk);
    check_all("R6 reset latched");
    check_val("R6", "g1 fall default", fall_code[9:5], CAL_I);

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op;
      op = $urandom % 3;
      if (op == 0) do_write($urandom % NG, 14'($urandom));
      else if (op == 1) do_cal(5'($urandom), 5'($urandom), 1'b1);
      else do_cal(5'($urandom), 5'($urandom), 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule